// File: doc/BRIEF.md
# Narrow Memory to 32-bit Bus Adapter

This block sits between a 32-bit processor bus and an external memory that is either 16 bits or 8 bits wide. The processor issues a single request for a whole word. The adapter then runs the narrow memory cycles needed to cover that word: two halfword cycles for a 16-bit device, or four byte cycles for an 8-bit device. It returns one 32-bit result with a single ready pulse. Reads are gathered most-significant part first into byte-lane holding registers. The last narrow beat is merged straight from the memory bus into the registered result. Writes put the matching byte lanes of the latched write word onto the 16-bit memory data bus, one beat at a time.

The 11-bit memory address is built from different slices of the processor address. A 16-bit device sees a halfword offset. An 8-bit device is treated as a multiplexed-address part: a row phase carries the upper address slice, and a column phase follows with the lower slice. Each strobe lasts a fixed number of clocks, set by parameter. The memory data bus is shown as a separate input, output and output enable, to be joined into a tristate pad at the chip edge.

Top module: `narrow_mem_adapter`

## Requirements
- R1: After reset, `bus_ready` is 0, `bus_rdata` is zero, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dout_en` and `mem_row_ph` are 0.
- R2: With `dev_wide`=1, a read runs two halfword beats. Beat 0 supplies `bus_rdata[31:16]` and beat 1 supplies `bus_rdata[15:0]`, both taken from `mem_din[15:0]`.
- R3: With `dev_wide`=0, a read runs four byte beats on `mem_din[7:0]`. Beat 0 lands in `bus_rdata[31:24]` and beat 3 lands in `bus_rdata[7:0]`. `mem_din[15:8]` has no effect.
- R4: With `dev_wide`=1, a write drives `bus_wdata[31:16]` on `mem_dout` in beat 0 and `bus_wdata[15:0]` in beat 1. `mem_dout_en` is 1 whenever `mem_we_n` is 0.
- R5: With `dev_wide`=0, beat k of a write drives byte `bus_wdata[31-8k -: 8]` on both halves of `mem_dout`.
- R6: In 16-bit mode, `mem_addr` = {3'b000, addr[8:2], beat[0]}.
- R7: In 8-bit mode, each beat opens with ROW_CLKS clocks in which `mem_row_ph`=1 and `mem_addr`=addr[19:9]. It then drives the column {addr[10:2], beat[1:0]}.
- R8: In each beat, `mem_oe_n` (read) or `mem_we_n` (write) is low for STRB_CLKS clocks, and never both at once. `mem_cs_n` is low during every phase. `bus_ready` rises 2·STRB_CLKS edges after the accepting edge for a 16-bit device, and 4·(ROW_CLKS+STRB_CLKS) edges after it for an 8-bit device.
- R9: `bus_ready` is high for exactly one cycle, and the read result is valid on `bus_rdata` in that cycle.
- R10: `bus_we`, `dev_wide`, `bus_addr` and `bus_wdata` are sampled only on the accepting edge. Changes made during a transfer have no effect.
- R11: A request held high during the `bus_ready` cycle is accepted on the next edge, so `mem_cs_n` is low in the following cycle.
- R12: A write leaves `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request; accepted when the adapter is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| dev_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| bus_addr | input | AW | Processor byte address |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Assembled read word (registered) |
| bus_ready | output | 1 | One-cycle completion pulse |
| mem_addr | output | 11 | Multiplexed memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_row_ph | output | 1 | High while the row address is on `mem_addr` |
| mem_dout | output | 16 | Memory write data |
| mem_dout_en | output | 1 | Output enable for `mem_dout` |
| mem_din | input | 16 | Memory read data |

## Verification
Two events can happen in the same cycle: the completion of one transfer, when `bus_ready` pulses, and the acceptance of the next request. The bench keeps `bus_req` high through an entire 16-bit read, with the inputs already changed to an 8-bit read. It then checks three things: the first result carries only the first request's data, the cycle after the pulse has `mem_cs_n` low with `bus_ready` low, and the second transfer's latency and word match the arithmetic for an 8-bit device. Around this case, every word offset is swept in both modes for reads and writes. The inputs are scrambled during each transfer, and the memory model puts junk on the unused upper byte lane.

// File: rtl/nma_pkg.sv
package nma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_STRB} nma_st_e;
  localparam int BUS_DW = 32;
  localparam int MEM_DW = 16;
  localparam int MEM_AW = 11;
endpackage

// File: rtl/nma_ctrl.sv
module nma_ctrl
  import nma_pkg::*;
#(
  parameter int STRB_CLKS = 2,
  parameter int ROW_CLKS  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       we,
  input  logic       wide,
  output nma_st_e    st,
  output logic [1:0] beat,
  output logic       lat_we,
  output logic       lat_wide,
  output logic       accept,
  output logic       beat_end,
  output logic       last_beat,
  output logic       ready
);
  localparam int MAXC = (STRB_CLKS > ROW_CLKS) ? STRB_CLKS : ROW_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          row_end;

  assign accept    = (st == ST_IDLE) && req;
  assign last_beat = lat_wide ? (beat == 2'd1) : (beat == 2'd3);
  assign beat_end  = (st == ST_STRB) && (cnt == CW'(STRB_CLKS - 1));
  assign row_end   = (st == ST_ROW) && (cnt == CW'(ROW_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      beat     <= '0;
      lat_we   <= 1'b0;
      lat_wide <= 1'b0;
      ready    <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            lat_we   <= we;
            lat_wide <= wide;
            beat     <= '0;
            cnt      <= '0;
            st       <= wide ? ST_STRB : ST_ROW;
          end
        end
        ST_ROW: begin
          if (row_end) begin
            cnt <= '0;
            st  <= ST_STRB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STRB: begin
          if (beat_end) begin
            cnt <= '0;
            if (last_beat) begin
              st    <= ST_IDLE;
              ready <= 1'b1;
            end else begin
              beat <= beat + 1'b1;
              st   <= lat_wide ? ST_STRB : ST_ROW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  assert_ready_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(st) == ST_STRB);
  assert_row_only_narrow_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ROW) |-> !lat_wide);
  assert_wide_two_beats_R6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && lat_wide) |-> beat <= 2'd1);
endmodule

// File: rtl/nma_addr_mux.sv
module nma_addr_mux
  import nma_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        beat,
  input  logic              wide,
  input  logic              row_ph,
  output logic [MEM_AW-1:0] mem_addr
);
  always_comb begin
    if (wide)
      mem_addr = {3'b000, addr[8:2], beat[0]};
    else if (row_ph)
      mem_addr = addr[19:9];
    else
      mem_addr = {addr[10:2], beat};
  end
endmodule

// File: rtl/nma_wr_steer.sv
module nma_wr_steer
  import nma_pkg::*;
(
  input  logic [BUS_DW-1:0] wdata,
  input  logic [1:0]        beat,
  input  logic              wide,
  output logic [MEM_DW-1:0] dout
);
  logic [7:0] sel_byte;

  always_comb begin
    case (beat)
      2'd0:    sel_byte = wdata[31:24];
      2'd1:    sel_byte = wdata[23:16];
      2'd2:    sel_byte = wdata[15:8];
      default: sel_byte = wdata[7:0];
    endcase
    if (wide)
      dout = beat[0] ? wdata[15:0] : wdata[31:16];
    else
      dout = {sel_byte, sel_byte};
  end
endmodule

// File: rtl/nma_rd_assemble.sv
module nma_rd_assemble
  import nma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              last,
  input  logic              wide,
  input  logic [1:0]        beat,
  input  logic [MEM_DW-1:0] din,
  output logic [BUS_DW-1:0] rdata
);
  for (genvar g = 0; g < 3; g++) begin : g_hold
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (cap) begin
        if (wide) begin
          if (g < 2 && beat == 2'd0) q <= din[15-8*g -: 8];
        end else if (beat == 2'(g)) begin
          q <= din[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (cap && last)
      rdata <= wide ? {g_hold[0].q, g_hold[1].q, din}
                    : {g_hold[0].q, g_hold[1].q, g_hold[2].q, din[7:0]};
  end
endmodule

// File: rtl/narrow_mem_adapter.sv
module narrow_mem_adapter
  import nma_pkg::*;
#(
  parameter int AW        = 20,
  parameter int STRB_CLKS = 2,
  parameter int ROW_CLKS  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic          dev_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_ready,
  output logic [10:0]   mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_row_ph,
  output logic [15:0]   mem_dout,
  output logic          mem_dout_en,
  input  logic [15:0]   mem_din
);
  nma_st_e         st;
  logic [1:0]      beat;
  logic            lat_we, lat_wide, accept, beat_end, last_beat;
  logic [AW-1:0]   addr_q;
  logic [31:0]     wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= bus_addr;
      wdata_q <= bus_wdata;
    end
  end

  nma_ctrl #(.STRB_CLKS(STRB_CLKS), .ROW_CLKS(ROW_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .wide(dev_wide),
    .st(st), .beat(beat), .lat_we(lat_we), .lat_wide(lat_wide),
    .accept(accept), .beat_end(beat_end), .last_beat(last_beat),
    .ready(bus_ready)
  );

  nma_addr_mux #(.AW(AW)) u_amux (
    .addr(addr_q), .beat(beat), .wide(lat_wide),
    .row_ph(st == ST_ROW), .mem_addr(mem_addr)
  );

  nma_wr_steer u_wsteer (
    .wdata(wdata_q), .beat(beat), .wide(lat_wide), .dout(mem_dout)
  );

  nma_rd_assemble u_rasm (
    .clk(clk), .rst(rst), .cap(beat_end && !lat_we), .last(last_beat),
    .wide(lat_wide), .beat(beat), .din(mem_din), .rdata(bus_rdata)
  );

  assign mem_cs_n    = (st == ST_IDLE);
  assign mem_row_ph  = (st == ST_ROW);
  assign mem_oe_n    = !((st == ST_STRB) && !lat_we);
  assign mem_we_n    = !((st == ST_STRB) && lat_we);
  assign mem_dout_en = (st != ST_IDLE) && lat_we;

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  assert_cs_covers_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n || mem_row_ph) |-> !mem_cs_n);
  assert_drive_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dout_en);
  assert_write_keeps_rdata_R12: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && lat_we) |=> $stable(bus_rdata));
endmodule

// File: tb/sim_narrow_mem_adapter.sv
module sim_narrow_mem_adapter;
  localparam int S = 2;
  localparam int R = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0, dev_wide = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [10:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_row_ph, mem_dout_en;
  logic [15:0] mem_dout, mem_din;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  narrow_mem_adapter #(.AW(20), .STRB_CLKS(S), .ROW_CLKS(R)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .dev_wide(dev_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_row_ph(mem_row_ph),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // memory model
  logic        mwide = 1'b1;
  logic [10:0] rowlat = '0;
  logic [15:0] wlog16 [256];
  logic [15:0] wlog8  [256];
  logic [10:0] wrow = '0;
  logic        en_err = 1'b0;

  function automatic logic [15:0] f16(input logic [7:0] h);
    return {h ^ 8'h3C, ~h};
  endfunction
  function automatic logic [7:0] f8(input logic [10:0] r, input logic [7:0] c);
    return c ^ {r[3:0], r[10:7]} ^ 8'h96;
  endfunction

  always_comb mem_din = mwide ? f16(mem_addr[7:0]) : {8'hEE, f8(rowlat, mem_addr[7:0])};

  always @(posedge clk) begin
    if (mem_row_ph) rowlat <= mem_addr;
    if (!mem_we_n) begin
      if (!mem_dout_en || mem_cs_n) en_err <= 1'b1;
      if (mwide) wlog16[mem_addr[7:0]] <= mem_dout;
      else begin
        wlog8[mem_addr[7:0]] <= mem_dout;
        wrow <= rowlat;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic wide, input logic [19:0] a);
    if (wide) return {f16({a[8:2], 1'b0}), f16({a[8:2], 1'b1})};
    return {f8(a[19:9], {a[7:2], 2'd0}), f8(a[19:9], {a[7:2], 2'd1}),
            f8(a[19:9], {a[7:2], 2'd2}), f8(a[19:9], {a[7:2], 2'd3})};
  endfunction

  function automatic int exp_lat(input logic wide);
    return wide ? 2 * S : 4 * (R + S);
  endfunction

  // Called at a negedge; returns at the negedge where bus_ready is high.
  task automatic xfer(input logic we, input logic wide, input logic [19:0] a,
                      input logic [31:0] d, output int lat);
    mwide = wide;
    bus_req = 1'b1; bus_we = we; dev_wide = wide; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    bus_we = ~we; dev_wide = ~wide; bus_addr = ~a; bus_wdata = ~d;  // R10 scramble
    lat = 0;
    while (!bus_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] held;
    logic [19:0] a, a2;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(bus_ready), 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 strobes", {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 32'd7);
    chk("R1 drive/row", {30'd0, mem_dout_en, mem_row_ph}, 0);

    // 16-bit sweep over every word offset
    for (int i = 0; i < 128; i++) begin
      a = {11'(i * 37 + 3), 7'(i), 2'b00};
      xfer(1'b0, 1'b1, a, 32'h0, lat);
      chk("R2/R6/R10 read16 data", bus_rdata, exp_rd(1'b1, a));
      chk("R8 read16 latency", 32'(lat), 32'(exp_lat(1'b1)));
      held = bus_rdata;
      @(negedge clk);
      chk("R9 ready single", 32'(bus_ready), 0);
      d = 32'h9E37_79B9 * (i + 1);
      xfer(1'b1, 1'b1, a, d, lat);
      chk("R8 write16 latency", 32'(lat), 32'(exp_lat(1'b1)));
      chk("R12 rdata kept", bus_rdata, held);
      chk("R4/R6 write16 hi", 32'(wlog16[{a[8:2], 1'b0}]), 32'(d[31:16]));
      chk("R4/R6 write16 lo", 32'(wlog16[{a[8:2], 1'b1}]), 32'(d[15:0]));
      @(negedge clk);
    end

    // 8-bit sweep
    for (int i = 0; i < 128; i++) begin
      a = {11'(i * 91 + 17), 7'(i), 2'b00};
      xfer(1'b0, 1'b0, a, 32'h0, lat);
      chk("R3/R7/R10 read8 data", bus_rdata, exp_rd(1'b0, a));
      chk("R8 read8 latency", 32'(lat), 32'(exp_lat(1'b0)));
      held = bus_rdata;
      @(negedge clk);
      chk("R9 ready single", 32'(bus_ready), 0);
      d = 32'h85EB_CA6B ^ (i * 32'h0101_0101);
      xfer(1'b1, 1'b0, a, d, lat);
      chk("R8 write8 latency", 32'(lat), 32'(exp_lat(1'b0)));
      chk("R12 rdata kept", bus_rdata, held);
      chk("R7 write8 row", 32'(wrow), 32'(a[19:9]));
      for (int k = 0; k < 4; k++)
        chk("R5 write8 byte", 32'(wlog8[{a[7:2], 2'(k)}]),
            32'({2{d[31 - 8 * k -: 8]}}));
      @(negedge clk);
    end

    chk("R4 drive enable during write", 32'(en_err), 0);

    // R11 back-to-back: completion and next acceptance in one cycle
    a  = 20'hA5C3C;
    a2 = 20'h3B7D4;
    mwide = 1'b1;
    bus_req = 1'b1; bus_we = 1'b0; dev_wide = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    dev_wide = 1'b0; bus_addr = a2;  // req stays high
    lat = 0;
    while (!bus_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 first data", bus_rdata, exp_rd(1'b1, a));
    chk("R11 first latency", 32'(lat), 32'(exp_lat(1'b1)));
    mwide = 1'b0;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R11 next started", {30'd0, mem_cs_n, bus_ready}, 0);
    lat = 0;
    while (!bus_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 second data", bus_rdata, exp_rd(1'b0, a2));
    chk("R11 second latency", 32'(lat), 32'(exp_lat(1'b0)));
    @(negedge clk);
    chk("R1 idle after", {31'd0, mem_cs_n}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule